// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic and logic stage of an 8-bit processor core. It takes an operation code, an accumulator value, a second operand and the condition flag byte that is current before the instruction. From these it combinationally forms an 8-bit result and the flag byte that the instruction leaves behind. The supported operations are increment, decrement, add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare. Every operation follows its own rule for updating the flags.

A flag register inside the block captures the new flag byte on a rising clock edge whenever the write strobe is high. The surrounding core normally feeds that register back into the flag input. The flag input is a separate port so that the core, or a test, can present any prior flag state. Compare updates the flags only: the value on the result port is the accumulator, unchanged. Operation codes outside the defined set leave both the accumulator and the flags as they were.

Top module: `alu8_core`

## Requirements
- R1: Flag byte layout is sign bit7, zero bit6, copy bit5, half carry bit4, copy bit3, parity/overflow bit2, subtract bit1, carry bit0. For every defined operation except compare, sign equals result bit7 and zero is set exactly when the result is 0x00. For compare, both are taken from the difference acc_in - opnd_in.
- R2: For every defined operation except compare, flag bits 5 and 3 equal bits 5 and 3 of the result.
- R3: Compare (code 9) forms the flags of acc_in - opnd_in, with bits 5 and 3 copied from opnd_in, and drives result_out with acc_in.
- R4: Increment (code 0) gives acc_in + 1 and decrement (code 1) gives acc_in - 1. Both ignore opnd_in, and both pass flags_in bit0 through to the new carry.
- R5: The subtract flag (bit1) is set for decrement, subtract, subtract with borrow and compare. It is cleared for every other defined operation.
- R6: Add with carry (code 3) and subtract with borrow (code 5) use flags_in bit0 as carry-in or borrow-in. Add (2), subtract (4) and compare ignore it. For add, subtract and compare, bit0 becomes the carry out of bit 7 or the borrow out of bit 7.
- R7: Half carry is the carry out of bit 3 for increment and additions, and the borrow into bit 4 for decrement, subtractions and compare. AND sets it; OR and XOR clear it.
- R8: For arithmetic operations, bit2 is two's-complement overflow. An addition overflows when both operands share a sign and the result sign differs from it. A subtraction overflows when the operand signs differ and the result sign differs from acc_in. Increment and decrement use an operand of 1.
- R9: AND (6), OR (7) and XOR (8) set bit2 when the result has an even number of ones, and clear bits 1 and 0.
- R10: Codes 10 to 15 drive result_out with acc_in and flags_next with flags_in.
- R11: flags_q loads flags_next on a rising clock edge when flag_we is high, and holds its value otherwise.
- R12: A low rst_n at a rising edge sets flags_q to 0xFF, whatever flag_we is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| flag_we | input | 1 | Flag register write strobe |
| alu_op | input | 4 | Operation code (0 increment ... 9 compare) |
| acc_in | input | 8 | Accumulator / first operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Flag byte in effect before the operation |
| result_out | output | 8 | Result (accumulator for compare and unused codes) |
| flags_next | output | 8 | Flag byte produced by the operation |
| flags_q | output | 8 | Registered flag byte |

## Verification
Two events can land on the same clock edge: a flag write requested by the strobe, and the synchronous reset. The bench holds rst_n low while flag_we is high and the operands select an operation whose new flag byte is 0x00. After that edge the register must read 0xFF. Before this, a write-only edge and a strobe-low edge confirm that the same operand pattern loads 0x00, and that nothing loads without the strobe. With those two results in hand, the 0xFF read can only come from reset taking priority.

// File: rtl/alu8_pkg.sv
// Package: shared flag positions, operation codes and control word for the
// 8-bit ALU. Assumes an 8-bit flag byte with the fixed bit layout below.
package alu8_pkg;

    localparam int FLAG_W = 8;
    localparam int FB_S   = 7;
    localparam int FB_Z   = 6;
    localparam int FB_Y   = 5;
    localparam int FB_H   = 4;
    localparam int FB_X   = 3;
    localparam int FB_PV  = 2;
    localparam int FB_N   = 1;
    localparam int FB_C   = 0;

    typedef enum logic [3:0] {
        OP_INC = 4'd0,
        OP_DEC = 4'd1,
        OP_ADD = 4'd2,
        OP_ADC = 4'd3,
        OP_SUB = 4'd4,
        OP_SBC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_CP  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic       valid;    // defined operation code
        logic       arith;    // adder path, else logic path
        logic       sub;      // subtract in adder
        logic       b_one;    // second adder operand is constant 1
        logic       use_cin;  // carry flag feeds adder
        logic       keep_c;   // carry flag passes through
        logic       cmp;      // compare: result is accumulator
        logic_sel_e lsel;     // logic function
    } alu_ctl_t;

endpackage

// File: rtl/alu8_op_decode.sv
// Module: alu8_op_decode
// Turns a 4-bit operation code into the control word for the adder and
// logic paths. Assumes codes 10..15 are undefined and marks them invalid.
module alu8_op_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctl_t   ctl
);

    // Purpose: map each operation code to its control fields.
    always_comb begin
        ctl         = '0;
        ctl.lsel    = LG_AND;
        ctl.valid   = 1'b1;
        case (op_code)
            OP_INC: begin ctl.arith = 1'b1; ctl.b_one = 1'b1; ctl.keep_c = 1'b1; end
            OP_DEC: begin ctl.arith = 1'b1; ctl.b_one = 1'b1; ctl.keep_c = 1'b1;
                          ctl.sub = 1'b1; end
            OP_ADD: begin ctl.arith = 1'b1; end
            OP_ADC: begin ctl.arith = 1'b1; ctl.use_cin = 1'b1; end
            OP_SUB: begin ctl.arith = 1'b1; ctl.sub = 1'b1; end
            OP_SBC: begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; end
            OP_AND: begin ctl.lsel = LG_AND; end
            OP_OR:  begin ctl.lsel = LG_OR;  end
            OP_XOR: begin ctl.lsel = LG_XOR; end
            OP_CP:  begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.cmp = 1'b1; end
            default: ctl.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_arith.sv
// Module: alu8_arith
// Add/subtract core with carry-in. Produces the sum or difference, the
// carry or borrow out of the top bit, the nibble half carry or borrow, and
// signed overflow. Assumes DATA_W is even.
module alu8_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              half,
    output logic              ovf
);

    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic [DATA_W:0] cin_ext;

    assign cin_ext = {{DATA_W{1'b0}}, cin};

    // Purpose: one extra bit wide add or subtract, the top bit is carry/borrow.
    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b} - cin_ext;
        else     wide = {1'b0, a} + {1'b0, b} + cin_ext;
    end

    assign res   = wide[DATA_W-1:0];
    assign carry = wide[DATA_W];
    // Carry or borrow across the nibble boundary appears as a flip at bit HALF_W.
    assign half  = a[HALF_W] ^ b[HALF_W] ^ res[HALF_W];

    // Purpose: signed overflow from operand and result signs.
    always_comb begin
        if (sub) ovf = (a[MSB] ^ b[MSB]) & (res[MSB] ^ a[MSB]);
        else     ovf = ~(a[MSB] ^ b[MSB]) & (res[MSB] ^ a[MSB]);
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: alu8_logic
// Bitwise AND/OR/XOR with an even-parity output. Assumes sel holds one of
// the three defined logic functions.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_sel_e        sel,
    output logic [DATA_W-1:0] res,
    output logic              par_even
);

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            // Purpose: per-bit function select.
            always_comb begin
                case (sel)
                    LG_OR:   res[gi] = a[gi] | b[gi];
                    LG_XOR:  res[gi] = a[gi] ^ b[gi];
                    default: res[gi] = a[gi] & b[gi];
                endcase
            end
        end
    endgenerate

    assign par_even = ~(^res);

endmodule

// File: rtl/alu8_flag_reg.sv
// Module: alu8_flag_reg
// Flag register with write strobe. Synchronous active-low reset loads
// RESET_VAL and overrides the strobe.
module alu8_flag_reg #(
    parameter int         FW        = 8,
    parameter logic [7:0] RESET_VAL = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] d,
    output logic [FW-1:0] q
);

    // Purpose: reset, load on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= FW'(RESET_VAL);
        else if (we) q <= d;
    end

endmodule

// File: rtl/alu8_core.sv
// Module: alu8_core (top)
// Combinational 8-bit ALU with per-operation flag rules, plus a strobed
// flag register. Assumes the flag layout of alu8_pkg and DATA_W of 8
// (the bit 5 and bit 3 copies need at least 6 bits).
module alu8_core
    import alu8_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter logic [7:0] FLAG_RST  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [3:0]        alu_op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result_out,
    output logic [7:0]        flags_next,
    output logic [7:0]        flags_q
);

    localparam int MSB = DATA_W - 1;

    alu_ctl_t          ctl;
    logic [DATA_W-1:0] ar_b;
    logic              ar_cin;
    logic [DATA_W-1:0] ar_res;
    logic              ar_carry;
    logic              ar_half;
    logic              ar_ovf;
    logic [DATA_W-1:0] lg_res;
    logic              lg_par;
    logic [DATA_W-1:0] flag_src;

    alu8_op_decode u_dec (
        .op_code (alu_op),
        .ctl     (ctl)
    );

    assign ar_b   = ctl.b_one ? DATA_W'(1) : opnd_in;
    assign ar_cin = ctl.use_cin & flags_in[FB_C];

    alu8_arith #(.DATA_W(DATA_W)) u_arith (
        .a     (acc_in),
        .b     (ar_b),
        .cin   (ar_cin),
        .sub   (ctl.sub),
        .res   (ar_res),
        .carry (ar_carry),
        .half  (ar_half),
        .ovf   (ar_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a        (acc_in),
        .b        (opnd_in),
        .sel      (ctl.lsel),
        .res      (lg_res),
        .par_even (lg_par)
    );

    // Purpose: source of the bit5/bit3 copies (operand for compare).
    assign flag_src = ctl.cmp ? opnd_in : (ctl.arith ? ar_res : lg_res);

    // Purpose: select result and assemble the new flag byte.
    always_comb begin
        result_out = acc_in;
        flags_next = flags_in;
        if (ctl.valid) begin
            if (ctl.arith) begin
                result_out        = ctl.cmp ? acc_in : ar_res;
                flags_next[FB_S]  = ar_res[MSB];
                flags_next[FB_Z]  = (ar_res == '0);
                flags_next[FB_H]  = ar_half;
                flags_next[FB_PV] = ar_ovf;
                flags_next[FB_N]  = ctl.sub;
                flags_next[FB_C]  = ctl.keep_c ? flags_in[FB_C] : ar_carry;
            end else begin
                result_out        = lg_res;
                flags_next[FB_S]  = lg_res[MSB];
                flags_next[FB_Z]  = (lg_res == '0);
                flags_next[FB_H]  = (ctl.lsel == LG_AND);
                flags_next[FB_PV] = lg_par;
                flags_next[FB_N]  = 1'b0;
                flags_next[FB_C]  = 1'b0;
            end
            flags_next[FB_Y] = flag_src[5];
            flags_next[FB_X] = flag_src[3];
        end
    end

    alu8_flag_reg #(.FW(FLAG_W), .RESET_VAL(FLAG_RST)) u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .d     (flags_next),
        .q     (flags_q)
    );

endmodule

// File: rtl/alu8_core_chk.sv
// Module: alu8_core_chk
// Property checker for alu8_core, attached through bind below.
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       flag_we,
    input logic [3:0] alu_op,
    input logic [7:0] acc_in,
    input logic [7:0] opnd_in,
    input logic [7:0] flags_in,
    input logic [7:0] result_out,
    input logic [7:0] flags_next,
    input logic [7:0] flags_q
);

    // R12
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> flags_q == 8'hFF);

    // R11
    hold_without_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));

    // R11
    load_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags_q == $past(flags_next));

    // R3
    compare_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_op == OP_CP |-> result_out == acc_in);

    // R4
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == OP_INC || alu_op == OP_DEC) |-> flags_next[FB_C] == flags_in[FB_C]);

    // R9
    logic_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == OP_AND || alu_op == OP_OR || alu_op == OP_XOR)
        |-> (flags_next[FB_PV] == ~(^result_out)) && !flags_next[FB_N] && !flags_next[FB_C]);

    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op < 4'd9) |-> flags_next[FB_Z] == (result_out == 8'h00));

    // R10
    undefined_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op > 4'd9) |-> (result_out == acc_in) && (flags_next == flags_in));

    // R3
    compare_copy_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_op == OP_CP |-> flags_next[FB_Y] == opnd_in[5] && flags_next[FB_X] == opnd_in[3]
                            && flags_next[FB_N]);

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_we    (flag_we),
    .alu_op     (alu_op),
    .acc_in     (acc_in),
    .opnd_in    (opnd_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .flags_next (flags_next),
    .flags_q    (flags_q)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       flag_we;
    logic [3:0] alu_op;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic [7:0] flags_in;
    logic [7:0] result_out;
    logic [7:0] flags_next;
    logic [7:0] flags_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_we    (flag_we),
        .alu_op     (alu_op),
        .acc_in     (acc_in),
        .opnd_in    (opnd_in),
        .flags_in   (flags_in),
        .result_out (result_out),
        .flags_next (flags_next),
        .flags_q    (flags_q)
    );

    // Entry: {op, acc, operand, flags before, expected result, expected flags}
    localparam int NV = 20;
    localparam logic [43:0] VEC [NV] = '{
        {4'd2, 8'h44, 8'h11, 8'h00, 8'h55, 8'h00},
        {4'd2, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94},
        {4'd2, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h51},
        {4'd3, 8'h0F, 8'h00, 8'h01, 8'h10, 8'h10},
        {4'd3, 8'h28, 8'h00, 8'h00, 8'h28, 8'h28},
        {4'd4, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h1A},
        {4'd4, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h3E},
        {4'd5, 8'h00, 8'h00, 8'h01, 8'hFF, 8'hBB},
        {4'd9, 8'h30, 8'h28, 8'h00, 8'h30, 8'h3A},
        {4'd9, 8'h05, 8'h05, 8'h00, 8'h05, 8'h42},
        {4'd0, 8'h7F, 8'hAA, 8'h01, 8'h80, 8'h95},
        {4'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h50},
        {4'd1, 8'h80, 8'h00, 8'h01, 8'h7F, 8'h3F},
        {4'd1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h42},
        {4'd6, 8'hF0, 8'h3C, 8'hFF, 8'h30, 8'h34},
        {4'd7, 8'h01, 8'h02, 8'hFF, 8'h03, 8'h04},
        {4'd8, 8'h5A, 8'h5A, 8'hFF, 8'h00, 8'h44},
        {4'd8, 8'hA8, 8'h00, 8'hFF, 8'hA8, 8'hA8},
        {4'd12, 8'h3C, 8'h99, 8'h5A, 8'h3C, 8'h5A},
        {4'd5, 8'h10, 8'h0F, 8'h01, 8'h00, 8'h52}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2:         return "R1 R8";
            3:               return "R6";
            4:               return "R2";
            5:               return "R7";
            6:               return "R8";
            7, 19:           return "R6 R5";
            8, 9:            return "R3";
            10, 11, 12, 13:  return "R4";
            14, 16, 17:      return "R9";
            15:              return "R7 R9";
            default:         return "R10";
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        alu_op   = op;
        acc_in   = a;
        opnd_in  = b;
        flags_in = f;
    endtask

    initial begin
        rst_n   = 1'b0;
        flag_we = 1'b0;
        drive(4'd0, 8'h00, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset value
        check8("R12 reset value", flags_q, 8'hFF);
        rst_n = 1'b1;

        // Vector table, strobe low throughout
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][43:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
            #1;
            check8({vec_tag(i), " result"}, result_out, VEC[i][15:8]);
            check8({vec_tag(i), " flags"}, flags_next, VEC[i][7:0]);
        end
        @(negedge clk);
        // R11: no strobe during the table, register still holds reset value
        check8("R11 hold without strobe", flags_q, 8'hFF);

        // R4: decrement wraps, carry 0 kept
        drive(4'd1, 8'h00, 8'h55, 8'h00);
        #1;
        check8("R4 dec wrap result", result_out, 8'hFF);
        check8("R4 dec wrap flags", flags_next, 8'hBA);
        @(negedge clk);
        // R4: increment with other flags set, carry 0 kept, half carry
        drive(4'd0, 8'h0F, 8'h00, 8'hFE);
        #1;
        check8("R4 inc nibble flags", flags_next, 8'h10);

        // R11: load with strobe
        @(negedge clk);
        drive(4'd2, 8'h44, 8'h11, 8'h00);
        flag_we = 1'b1;
        @(negedge clk);
        check8("R11 load with strobe", flags_q, 8'h00);
        // R11: strobe low, new operands must not load
        flag_we = 1'b0;
        drive(4'd2, 8'h7F, 8'h01, 8'h00);
        @(negedge clk);
        check8("R11 hold new operands", flags_q, 8'h00);
        flag_we = 1'b1;
        @(negedge clk);
        check8("R11 load overflow flags", flags_q, 8'h94);

        // R12: reset and strobe on the same edge, reset wins
        drive(4'd2, 8'h44, 8'h11, 8'h00);
        rst_n   = 1'b0;
        flag_we = 1'b1;
        @(negedge clk);
        check8("R12 reset over strobe", flags_q, 8'hFF);
        rst_n   = 1'b1;
        flag_we = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule